// File: doc/BRIEF.md
# Dual-Clock Elastic Buffer

This block carries one data word per cycle from a write clock domain into a read clock domain. The two clocks are assumed to come from one oscillator, so they have the same frequency. Their relative phase is fixed but not known at design time. The block holds a small ring of storage. The writer deposits a word into it on every write-clock edge, and the reader collects a word from it on every read-clock edge. Neither side can pause the other.

There is no valid/ready pairing and no back-pressure in either direction. The upstream logic must present a fresh word on every write cycle, and the downstream logic takes whatever emerges on every read cycle. Correct operation rests on three points:
- the clock rates are equal;
- the pointers begin half the ring apart;
- the read side leaves reset only after the write side has done so.

No logic watches for the pointers meeting. A single asynchronous reset input is brought cleanly into each domain. The read-side synchroniser is fed from the write-side one, so the release order is fixed.

Top module: `elastic_buffer`

## Requirements
- R1: While `arst_n` is low, `rd_data` is zero; asserting `arst_n` forces `rd_data` to zero without waiting for a clock edge, and it stays zero until the read side leaves reset.
- R2: The write side leaves reset on the second `wr_clk` rising edge after `arst_n` rises. From the third edge on, it stores the word on `wr_data` at every `wr_clk` rising edge, with no enable. The word sampled at that third edge is the first word to emerge on `rd_data`.
- R3: The read side leaves reset only after the write side has left it, two `rd_clk` rising edges later, because its synchroniser takes the write-side reset as its input.
- R4: The read pointer starts DEPTH/2 entries behind the write pointer, and the ring is cleared to zero by reset. With `rd_clk` lagging `wr_clk` by less than half a period, `rd_data` reads zero after each of the first DEPTH/2+3 `rd_clk` rising edges that follow the rise of `arst_n` (made at a `wr_clk` falling edge). The first stored word appears after rising edge DEPTH/2+4.
- R5: Once data flows, `rd_data` advances by exactly one input word per `rd_clk` cycle, in input order, with no word lost or repeated, and the spacing between the pointers stays constant.
- R6: DEPTH is a power of two and at least 4. Both pointers wrap modulo DEPTH, so streams much longer than DEPTH pass through unchanged.
- R7: Asserting `arst_n` mid-stream discards the stored words. After the next release, the block repeats exactly the R4 start-up timing, with zeros in place of the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous active-low reset, synchronised into each domain |
| wr_clk | input | 1 | Write-domain clock |
| wr_data | input | DW | Word stored at every `wr_clk` rising edge |
| rd_clk | input | 1 | Read-domain clock, same frequency as `wr_clk` |
| rd_data | output | DW | Registered word read at every `rd_clk` rising edge |

## Verification
With `rd_clk` lagging `wr_clk` by 7 ns, `arst_n` is released on a `wr_clk` falling edge. The word presented for the third `wr_clk` rising edge after that release is due on `rd_data` after read edge DEPTH/2+4. Each later word is due exactly one read cycle after the one before it.

The bench drives `wr_data` on write falling edges and samples `rd_data` on read falling edges. It counts read edges from the release, expects zero for the first DEPTH/2+3 samples, and then expects the stimulus words strictly by position. An asynchronous reset is checked 1 ns after it is applied.

// File: rtl/elbuf_pkg.sv
package elbuf_pkg;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int unsigned ring_half(input int unsigned depth);
    return depth / 2;
  endfunction

endpackage

// File: rtl/elbuf_rst_sync.sv
module elbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rel_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], rel_in};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/elbuf_ptr.sv
module elbuf_ptr #(
  parameter int AW   = 3,
  parameter int INIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] ptr_q
);
  localparam logic [AW-1:0] START = AW'(INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= START;
    else        ptr_q <= ptr_q + 1'b1;
  end
endmodule

// File: rtl/elbuf_store.sv
module elbuf_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_word,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] ring_q [DEPTH];

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring_q[i] <= '0;
    end else begin
      ring_q[wr_addr] <= wr_word;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rd_word <= '0;
    else           rd_word <= ring_q[rd_addr];
  end
endmodule

// File: rtl/elastic_buffer.sv
module elastic_buffer #(
  parameter int DW          = 16,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          arst_n,
  input  logic          wr_clk,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  output logic [DW-1:0] rd_data
);
  import elbuf_pkg::*;

  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = ring_half(DEPTH);

  initial begin
    assert (is_pow2(DEPTH) && DEPTH >= 4 && SYNC_STAGES >= 2)
      else $fatal(1, "elastic_buffer: DEPTH must be a power of two >= 4");
  end

  logic          wr_rst_n;
  logic          rd_rst_n;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  // Write side releases first; read side is chained behind it.
  elbuf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(wr_clk), .arst_n(arst_n), .rel_in(1'b1), .rst_n_out(wr_rst_n)
  );

  elbuf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(rd_clk), .arst_n(arst_n), .rel_in(wr_rst_n), .rst_n_out(rd_rst_n)
  );

  // Pointers start half a ring apart.
  elbuf_ptr #(.AW(AW), .INIT(HALF)) u_wr_ptr (
    .clk(wr_clk), .rst_n(wr_rst_n), .ptr_q(wr_ptr)
  );

  elbuf_ptr #(.AW(AW), .INIT(0)) u_rd_ptr (
    .clk(rd_clk), .rst_n(rd_rst_n), .ptr_q(rd_ptr)
  );

  elbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .wr_clk  (wr_clk),
    .wr_rst_n(wr_rst_n),
    .wr_addr (wr_ptr),
    .wr_word (wr_data),
    .rd_clk  (rd_clk),
    .rd_rst_n(rd_rst_n),
    .rd_addr (rd_ptr),
    .rd_word (rd_data)
  );
endmodule

// File: rtl/elbuf_checker.sv
module elbuf_checker #(
  parameter int DW   = 16,
  parameter int AW   = 3,
  parameter int HALF = 4
) (
  input logic          arst_n,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n,
  input logic          rd_rst_n,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [DW-1:0] rd_data
);
  logic [AW-1:0] gap;
  logic [AW-1:0] gap_off;
  assign gap     = wr_ptr - rd_ptr;
  assign gap_off = gap - AW'(HALF);

  AST_RD_ZERO_IN_RESET: assert property (@(posedge rd_clk) disable iff (!arst_n) !rd_rst_n |-> rd_data == '0); // R1
  AST_RD_AFTER_WR: assert property (@(posedge rd_clk) disable iff (!arst_n) rd_rst_n |-> wr_rst_n); // R3
  AST_WR_PTR_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n) wr_rst_n |=> wr_ptr == $past(wr_ptr) + 1'b1); // R6
  AST_RD_PTR_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) rd_rst_n |=> rd_ptr == $past(rd_ptr) + 1'b1); // R5
  AST_GAP_CONST: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) rd_rst_n |=> $stable(gap)); // R5
  AST_GAP_WINDOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) rd_rst_n |-> (gap_off >= 1 && gap_off <= 3)); // R4
endmodule

bind elastic_buffer elbuf_checker #(.DW(DW), .AW(AW), .HALF(HALF)) u_chk (
  .arst_n  (arst_n),
  .wr_clk  (wr_clk),
  .rd_clk  (rd_clk),
  .wr_rst_n(wr_rst_n),
  .rd_rst_n(rd_rst_n),
  .wr_ptr  (wr_ptr),
  .rd_ptr  (rd_ptr),
  .rd_data (rd_data)
);

// File: tb/tb_elastic_buffer.sv
module tb_elastic_buffer;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;
  localparam int NSTIM = 20;

  // Stimulus words; the expected output is the same word, by position.
  localparam logic [DW-1:0] STIM [NSTIM] = '{
    16'h0001, 16'hFFFF, 16'h8000, 16'h5555, 16'hAAAA,
    16'h0000, 16'h1234, 16'hFEDC, 16'h00FF, 16'hFF00,
    16'h7FFF, 16'h0F0F, 16'hF0F0, 16'h3C3C, 16'hC3C3,
    16'h0002, 16'h4000, 16'hBEEF, 16'h0101, 16'h9999
  };

  logic          wr_clk  = 1'b0;
  logic          rd_clk  = 1'b0;
  logic          arst_n  = 1'b0;
  logic [DW-1:0] wr_data = 16'hDEAD;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  elastic_buffer #(.DW(DW), .DEPTH(DEPTH)) dut (
    .arst_n (arst_n),
    .wr_clk (wr_clk),
    .wr_data(wr_data),
    .rd_clk (rd_clk),
    .rd_data(rd_data)
  );

  always #10 wr_clk = ~wr_clk;

  initial begin
    #17;
    forever begin
      rd_clk = ~rd_clk;
      #10;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_stream(input int first, input int n);
    @(negedge wr_clk);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_data = STIM[(first + i) % NSTIM];
    end
  endtask

  task automatic read_stream(input string fill_tag, input int first, input int n);
    for (int k = 0; k < HALF + 4 + n; k++) begin
      @(negedge rd_clk);
      if (k <= HALF + 3) begin
        check(fill_tag, rd_data, '0);
      end else begin
        int j;
        j = k - (HALF + 4);
        if (j == 0)          check("R2 first word", rd_data, STIM[first % NSTIM]);
        else if (j >= DEPTH) check("R6 wrapped word", rd_data, STIM[(first + j) % NSTIM]);
        else                 check("R5 order", rd_data, STIM[(first + j) % NSTIM]);
      end
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // Reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge rd_clk);
      check("R1 reset state", rd_data, '0);
    end

    // Table-driven stream, longer than the ring
    @(negedge wr_clk);
    arst_n = 1'b1;
    fork
      write_stream(0, NSTIM);
      read_stream("R3 R4 fill", 0, NSTIM);
    join

    // Directed: asynchronous reset in the middle of traffic
    repeat (3) @(negedge wr_clk);
    #3;
    arst_n = 1'b0;
    #1;
    check("R1 async clear", rd_data, '0);
    for (int i = 0; i < 4; i++) begin
      @(negedge rd_clk);
      check("R1 held in reset", rd_data, '0);
    end

    // Directed: restart, stored words must be gone and timing repeated
    wr_data = 16'hDEAD;
    @(negedge wr_clk);
    arst_n = 1'b1;
    fork
      write_stream(7, 12);
      read_stream("R7 restart fill", 7, 12);
    join

    done = 1'b1;
    summary();
    $finish;
  end
endmodule